// File: doc/BRIEF.md
# Indirect Branch Target Repair Walker

This controller runs once an indirect branch has resolved and decides how the pointer-based target store must be repaired. Each indirect branch owns up to `SLOTS` target slots in the branch target buffer. A per-branch allocation entry, stored at the branch PC, holds a bitmask of the slots in use. A slot is reached through a hashed address built from the branch PC and the slot's pointer.

When the prediction was right, the controller touches the replacement state of the slot it used and does nothing else. On a misprediction it visits the allocated slots in ascending pointer order, one per cycle. Slots that no longer hit in the buffer are dropped from the mask. If a visited slot already holds the resolved target, the walk stops and that slot's pointer becomes the training value; this is a stale-pointer repair. If no slot matches, the resolved target is written into a pseudo-randomly chosen free slot. When every slot is taken, a pseudo-randomly chosen used slot is overwritten instead. Whenever the mask changes, or the allocation entry did not exist, the mask is written back. The pointer handed back on completion is the value the pointer-bit predictors are trained toward.

Updates arrive on a valid/ready interface. `upd_ready` is high only while the controller is idle, so an upstream source must hold `upd_valid` and its payload until a cycle in which both are high. One update is in flight at a time. The buffer port has a combinational lookup response and accepts one read or one write per cycle. Results are presented for the single cycle in which `done` is high.

Top module: `itu_ctrl`

## Requirements
- R1: `upd_ready` is 1 exactly when the controller is idle, and `busy` is its inverse. An update is accepted on a clock edge where `upd_valid` and `upd_ready` are both 1. Any request presented while busy is not taken until after `done`.
- R2: With `upd_mispredict`=0, the cycle after acceptance raises `lru_touch` for one cycle with `lru_addr` = hash(PC, `upd_ptr`). No buffer access happens in that cycle. `done` follows in the next cycle with `res_ptr` = `upd_ptr`, `res_kind`=0, `res_train`=0 and the incoming mask unchanged.
- R3: The hash of PC and pointer p flips the top `PTR_W` bits of the PC by p and the low `PTR_W` bits by the bitwise complement of p. A slot address therefore never equals the PC.
- R4: On a misprediction, each cycle issues one read (`btb_en`=1, `btb_we`=0) at the hash of the lowest-numbered allocated slot not yet visited. Slots whose mask bit is 0 are never read.
- R5: A read that misses clears that slot's bit in the mask.
- R6: A read that hits with data equal to the resolved target ends the walk with `res_kind`=1, `res_ptr` = that slot and `res_train`=1.
- R7: If the walk ends without a match and the mask has a 0 bit, the next cycle writes the target at the hash of the first free slot at or after the random start, in wrap-around order. That slot's bit is then set, and `res_kind`=2 and `res_train`=1.
- R8: If the walk ends without a match and the mask is all ones, the slot at the random start is overwritten with the target. The mask is not written back, and `res_kind`=3 and `res_train`=1.
- R9: When `upd_entry_found`=0, `upd_mask` is ignored and treated as zero. If the mask changed or the entry was missing, one write at address PC carries the mask zero-extended in the low bits of the data word.
- R10: `done` is a single-cycle pulse. It comes 2 cycles after acceptance for a correct prediction. For a match after V visits it comes V+1 cycles after acceptance, or V+2 if any bit was cleared. For an allocation it comes V+3 cycles after, and for a replacement V+2.
- R11: The random start is the low `PTR_W` bits of a 16-bit shift register. The register is loaded with `LFSR_SEED` in reset and shifts left every cycle, taking bit15^bit13^bit12^bit10 as its new bit 0. The value present in the cycle of the slot write is the one used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_valid | input | 1 | Update request valid |
| upd_ready | output | 1 | Controller idle, can accept an update |
| upd_pc | input | PC_W | Branch PC |
| upd_target | input | TGT_W | Resolved target |
| upd_ptr | input | PTR_W | Pointer used for the prediction |
| upd_mispredict | input | 1 | 1 if the prediction was wrong |
| upd_entry_found | input | 1 | Allocation entry was present |
| upd_mask | input | SLOTS | Allocation mask from the entry |
| btb_en | output | 1 | Buffer access this cycle |
| btb_we | output | 1 | Access is a write |
| btb_addr | output | PC_W | Access address |
| btb_wdata | output | TGT_W | Write data |
| btb_hit | input | 1 | Lookup hit for `btb_addr` (same cycle) |
| btb_rdata | input | TGT_W | Lookup data (same cycle) |
| lru_touch | output | 1 | Replacement-state touch strobe |
| lru_addr | output | PC_W | Address to touch |
| busy | output | 1 | Update in progress |
| done | output | 1 | Result valid this cycle |
| res_kind | output | 2 | 0 correct, 1 stale pointer, 2 allocated, 3 replaced |
| res_ptr | output | PTR_W | Pointer for predictor training |
| res_mask | output | SLOTS | Updated allocation mask |
| res_train | output | 1 | Predictors must train toward `res_ptr` |

## Verification
Every buffer access is due in a fixed cycle after acceptance: the k-th allocated slot is read k cycles after the accepting edge. The slot write comes one cycle after the last read, and the mask write one cycle later. `done` lands at the latency given in R10. Before presenting each update, the bench computes the full per-cycle access schedule and the `done` cycle from its own buffer model and its own shift-register copy. It then compares the ports at every falling edge between acceptance and idle, so an access or result one cycle early or late is caught.

// File: rtl/itu_pkg.sv
package itu_pkg;
  typedef enum logic [1:0] {
    KIND_HIT     = 2'd0,
    KIND_REPOINT = 2'd1,
    KIND_ALLOC   = 2'd2,
    KIND_REPLACE = 2'd3
  } upd_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TOUCH,
    ST_WALK,
    ST_MASKWR,
    ST_DONE
  } walk_st_e;
endpackage

// File: rtl/itu_lfsr.sv
module itu_lfsr #(
  parameter logic [15:0] SEED  = 16'hACE1,
  parameter int          OUT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [OUT_W-1:0] q
);
  logic [15:0] state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= {state_q[14:0], state_q[15] ^ state_q[13] ^ state_q[12] ^ state_q[10]};
  end

  assign q = state_q[OUT_W-1:0];
endmodule

// File: rtl/itu_pick.sv
// First set candidate at or after start, wrapping; N must be a power of two.
module itu_pick #(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     cand,
  input  logic [IDX_W-1:0] start,
  output logic [IDX_W-1:0] idx
);
  always_comb begin : scan
    logic [IDX_W-1:0] pos;
    logic             found;
    idx   = '0;
    found = 1'b0;
    for (int k = 0; k < N; k++) begin
      pos = start + IDX_W'(k);
      if (!found && cand[pos]) begin
        idx   = pos;
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/itu_hash.sv
module itu_hash #(
  parameter int PC_W  = 32,
  parameter int PTR_W = 4
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [PTR_W-1:0] ptr,
  output logic [PC_W-1:0]  addr
);
  localparam int GAP = PC_W - PTR_W;

  assign addr = pc ^ {ptr, {GAP{1'b0}}} ^ {{GAP{1'b0}}, ~ptr};
endmodule

// File: rtl/itu_ctrl.sv
module itu_ctrl
  import itu_pkg::*;
#(
  parameter int          PC_W      = 32,
  parameter int          TGT_W     = 32,
  parameter int          SLOTS     = 16,
  parameter logic [15:0] LFSR_SEED = 16'hACE1,
  localparam int         PTR_W     = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_valid,
  output logic             upd_ready,
  input  logic [PC_W-1:0]  upd_pc,
  input  logic [TGT_W-1:0] upd_target,
  input  logic [PTR_W-1:0] upd_ptr,
  input  logic             upd_mispredict,
  input  logic             upd_entry_found,
  input  logic [SLOTS-1:0] upd_mask,
  output logic             btb_en,
  output logic             btb_we,
  output logic [PC_W-1:0]  btb_addr,
  output logic [TGT_W-1:0] btb_wdata,
  input  logic             btb_hit,
  input  logic [TGT_W-1:0] btb_rdata,
  output logic             lru_touch,
  output logic [PC_W-1:0]  lru_addr,
  output logic             busy,
  output logic             done,
  output logic [1:0]       res_kind,
  output logic [PTR_W-1:0] res_ptr,
  output logic [SLOTS-1:0] res_mask,
  output logic             res_train
);
  localparam int PAD_W = TGT_W - SLOTS;

  walk_st_e         st_q;
  upd_kind_e        kind_q;
  logic [PC_W-1:0]  pc_q;
  logic [TGT_W-1:0] tgt_q;
  logic [PTR_W-1:0] ptr_q;
  logic [SLOTS-1:0] mask_q;
  logic [SLOTS-1:0] pend_q;
  logic             dirty_q;

  logic [PTR_W-1:0] rnd_start;
  logic [PTR_W-1:0] walk_idx;
  logic [PTR_W-1:0] rnd_idx;
  logic [PTR_W-1:0] hash_ptr;
  logic [PC_W-1:0]  hash_addr;
  logic [SLOTS-1:0] rnd_cand;
  logic             walk_any;
  logic             mask_full;

  itu_lfsr #(.SEED(LFSR_SEED), .OUT_W(PTR_W)) u_lfsr (
    .clk  (clk),
    .rst_n(rst_n),
    .q    (rnd_start)
  );

  itu_pick #(.N(SLOTS), .IDX_W(PTR_W)) u_walk_pick (
    .cand (pend_q),
    .start('0),
    .idx  (walk_idx)
  );

  assign mask_full = &mask_q;
  assign rnd_cand  = mask_full ? {SLOTS{1'b1}} : ~mask_q;

  itu_pick #(.N(SLOTS), .IDX_W(PTR_W)) u_rnd_pick (
    .cand (rnd_cand),
    .start(rnd_start),
    .idx  (rnd_idx)
  );

  assign walk_any = |pend_q;
  assign hash_ptr = (st_q == ST_TOUCH) ? ptr_q : (walk_any ? walk_idx : rnd_idx);

  itu_hash #(.PC_W(PC_W), .PTR_W(PTR_W)) u_hash (
    .pc  (pc_q),
    .ptr (hash_ptr),
    .addr(hash_addr)
  );

  // Port drive
  always_comb begin
    btb_en    = 1'b0;
    btb_we    = 1'b0;
    btb_addr  = '0;
    btb_wdata = '0;
    unique case (st_q)
      ST_WALK: begin
        btb_en   = 1'b1;
        btb_addr = hash_addr;
        if (!walk_any) begin
          btb_we    = 1'b1;
          btb_wdata = tgt_q;
        end
      end
      ST_MASKWR: begin
        btb_en    = 1'b1;
        btb_we    = 1'b1;
        btb_addr  = pc_q;
        btb_wdata = {{PAD_W{1'b0}}, mask_q};
      end
      default: ;
    endcase
  end

  assign upd_ready = (st_q == ST_IDLE);
  assign busy      = (st_q != ST_IDLE);
  assign lru_touch = (st_q == ST_TOUCH);
  assign lru_addr  = hash_addr;
  assign done      = (st_q == ST_DONE);
  assign res_kind  = kind_q;
  assign res_ptr   = ptr_q;
  assign res_mask  = mask_q;
  assign res_train = (kind_q != KIND_HIT);

  // Sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      kind_q  <= KIND_HIT;
      pc_q    <= '0;
      tgt_q   <= '0;
      ptr_q   <= '0;
      mask_q  <= '0;
      pend_q  <= '0;
      dirty_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (upd_valid) begin
            pc_q    <= upd_pc;
            tgt_q   <= upd_target;
            ptr_q   <= upd_ptr;
            kind_q  <= KIND_HIT;
            mask_q  <= upd_entry_found ? upd_mask : '0;
            pend_q  <= (upd_entry_found && upd_mispredict) ? upd_mask : '0;
            dirty_q <= !upd_entry_found;
            st_q    <= upd_mispredict ? ST_WALK : ST_TOUCH;
          end
        end
        ST_TOUCH: st_q <= ST_DONE;
        ST_WALK: begin
          if (walk_any) begin
            pend_q[walk_idx] <= 1'b0;
            if (!btb_hit) begin
              mask_q[walk_idx] <= 1'b0;
              dirty_q          <= 1'b1;
            end else if (btb_rdata == tgt_q) begin
              ptr_q  <= walk_idx;
              kind_q <= KIND_REPOINT;
              st_q   <= dirty_q ? ST_MASKWR : ST_DONE;
            end
          end else begin
            ptr_q <= rnd_idx;
            if (mask_full) begin
              kind_q <= KIND_REPLACE;
              st_q   <= ST_DONE;
            end else begin
              mask_q[rnd_idx] <= 1'b1;
              kind_q          <= KIND_ALLOC;
              dirty_q         <= 1'b1;
              st_q            <= ST_MASKWR;
            end
          end
        end
        ST_MASKWR: st_q <= ST_DONE;
        ST_DONE:   st_q <= ST_IDLE;
        default:   st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/itu_ctrl_chk.sv
module itu_ctrl_chk #(
  parameter int SLOTS = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             upd_valid,
  input logic             upd_ready,
  input logic             busy,
  input logic             done,
  input logic             btb_en,
  input logic             lru_touch,
  input logic [1:0]       res_kind,
  input logic [SLOTS-1:0] res_mask
);
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid && upd_ready |=> busy); // R1

  AST_TOUCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    lru_touch |-> !btb_en); // R2

  AST_BTB_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    btb_en |-> busy); // R4

  AST_ALLOC_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    done && res_kind == 2'd2 |-> res_mask != '0); // R7

  AST_REPLACE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    done && res_kind == 2'd3 |-> &res_mask); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> upd_ready); // R10
endmodule

bind itu_ctrl itu_ctrl_chk #(.SLOTS(SLOTS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .upd_valid(upd_valid),
  .upd_ready(upd_ready),
  .busy     (busy),
  .done     (done),
  .btb_en   (btb_en),
  .lru_touch(lru_touch),
  .res_kind (res_kind),
  .res_mask (res_mask)
);

// File: tb/itu_ctrl_tb_top.sv
module itu_ctrl_tb_top;
  localparam int          DEPTH = 64;
  localparam logic [15:0] SEED  = 16'hACE1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        upd_valid = 1'b0;
  logic        upd_ready;
  logic [31:0] upd_pc = '0;
  logic [31:0] upd_target = '0;
  logic [3:0]  upd_ptr = '0;
  logic        upd_mispredict = 1'b0;
  logic        upd_entry_found = 1'b0;
  logic [15:0] upd_mask = '0;
  logic        btb_en, btb_we;
  logic [31:0] btb_addr, btb_wdata;
  logic        btb_hit;
  logic [31:0] btb_rdata;
  logic        lru_touch;
  logic [31:0] lru_addr;
  logic        busy, done, res_train;
  logic [1:0]  res_kind;
  logic [3:0]  res_ptr;
  logic [15:0] res_mask;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  itu_ctrl #(.PC_W(32), .TGT_W(32), .SLOTS(16), .LFSR_SEED(SEED)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .upd_valid(upd_valid), .upd_ready(upd_ready), .upd_pc(upd_pc),
    .upd_target(upd_target), .upd_ptr(upd_ptr), .upd_mispredict(upd_mispredict),
    .upd_entry_found(upd_entry_found), .upd_mask(upd_mask),
    .btb_en(btb_en), .btb_we(btb_we), .btb_addr(btb_addr), .btb_wdata(btb_wdata),
    .btb_hit(btb_hit), .btb_rdata(btb_rdata),
    .lru_touch(lru_touch), .lru_addr(lru_addr),
    .busy(busy), .done(done), .res_kind(res_kind), .res_ptr(res_ptr),
    .res_mask(res_mask), .res_train(res_train)
  );

  // Behavioural target buffer
  logic        bv [DEPTH];
  logic [31:0] ba [DEPTH];
  logic [31:0] bd [DEPTH];
  logic [1:0]  pre_op = 2'd0;
  logic [31:0] pre_a = '0, pre_d = '0;

  task automatic mwrite(input logic [31:0] a, input logic [31:0] d);
    int slot = -1;
    for (int i = 0; i < DEPTH; i++) if (bv[i] && ba[i] == a) slot = i;
    for (int i = 0; i < DEPTH; i++) if (slot < 0 && !bv[i]) slot = i;
    if (slot >= 0) begin bv[slot] = 1'b1; ba[slot] = a; bd[slot] = d; end
  endtask

  task automatic mkill(input logic [31:0] a);
    for (int i = 0; i < DEPTH; i++) if (bv[i] && ba[i] == a) bv[i] = 1'b0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) bv[i] = 1'b0;
    end else begin
      if (btb_en && btb_we) mwrite(btb_addr, btb_wdata);
      if (pre_op == 2'd1) mwrite(pre_a, pre_d);
      else if (pre_op == 2'd2) mkill(pre_a);
    end
  end

  function automatic logic mhit(input logic [31:0] a);
    logic h = 1'b0;
    for (int i = 0; i < DEPTH; i++) if (bv[i] && ba[i] == a) h = 1'b1;
    return h;
  endfunction

  function automatic logic [31:0] mdata(input logic [31:0] a);
    logic [31:0] d = '0;
    for (int i = 0; i < DEPTH; i++) if (bv[i] && ba[i] == a) d = bd[i];
    return d;
  endfunction

  always_comb begin
    btb_hit   = 1'b0;
    btb_rdata = '0;
    for (int i = 0; i < DEPTH; i++)
      if (bv[i] && ba[i] == btb_addr) begin
        btb_hit   = 1'b1;
        btb_rdata = bd[i];
      end
  end

  // Bench copy of the random source, from R11
  function automatic logic [15:0] bstep(input logic [15:0] x);
    return {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
  endfunction

  logic [15:0] blfsr;
  always @(posedge clk) begin
    if (!rst_n) blfsr <= SEED;
    else        blfsr <= bstep(blfsr);
  end

  // Slot address from R3
  function automatic logic [31:0] bh(input logic [31:0] pc, input int s);
    logic [3:0] p = 4'(s);
    return pc ^ {p, 28'h0} ^ {28'h0, ~p};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic put(input logic [31:0] a, input logic [31:0] d);
    pre_op = 2'd1; pre_a = a; pre_d = d;
    @(negedge clk);
    pre_op = 2'd0;
  endtask

  task automatic kill(input logic [31:0] a);
    pre_op = 2'd2; pre_a = a;
    @(negedge clk);
    pre_op = 2'd0;
  endtask

  // One update: reference schedule, then per-cycle compare. Called at a falling edge.
  task automatic run(input logic [31:0] pc, input logic [31:0] tgt, input logic [3:0] ptr,
                     input logic mis, input logic found, input logic [15:0] mask,
                     input logic hold, input string rq);
    int          eop [32];
    logic [31:0] ea  [32];
    logic [31:0] ed  [32];
    logic [15:0] m, lw;
    logic        dirty, matched, full, got;
    int          v, lat, kind, eptr, st, idx;
    for (int i = 0; i < 32; i++) begin eop[i] = 0; ea[i] = '0; ed[i] = '0; end
    m = found ? mask : 16'h0;
    dirty = !found; matched = 1'b0; v = 0; eptr = 0; kind = 0; lat = 2;
    if (!mis) begin
      eptr = ptr;
    end else begin
      for (int s = 0; s < 16; s++) begin
        if (!matched && m[s]) begin
          v++;
          eop[v] = 1; ea[v] = bh(pc, s);
          if (!mhit(bh(pc, s))) begin m[s] = 1'b0; dirty = 1'b1; end
          else if (mdata(bh(pc, s)) == tgt) begin matched = 1'b1; eptr = s; end
        end
      end
      if (matched) begin
        kind = 1;
        if (dirty) begin
          eop[v+1] = 2; ea[v+1] = pc; ed[v+1] = {16'h0, m}; lat = v + 2;
        end else lat = v + 1;
      end else begin
        lw = blfsr;
        for (int k = 0; k <= v; k++) lw = bstep(lw);
        full = (m == 16'hFFFF);
        st = int'(lw[3:0]);
        got = 1'b0;
        for (int k = 0; k < 16; k++) begin
          idx = (st + k) % 16;
          if (!got && (full || !m[idx])) begin eptr = idx; got = 1'b1; end
        end
        eop[v+1] = 2; ea[v+1] = bh(pc, eptr); ed[v+1] = tgt;
        if (full) begin
          kind = 3; lat = v + 2;
        end else begin
          m[eptr] = 1'b1; kind = 2;
          eop[v+2] = 2; ea[v+2] = pc; ed[v+2] = {16'h0, m}; lat = v + 3;
        end
      end
    end
    upd_valid = 1'b1; upd_pc = pc; upd_target = tgt; upd_ptr = ptr;
    upd_mispredict = mis; upd_entry_found = found; upd_mask = mask;
    @(posedge clk);
    @(negedge clk);
    if (!hold) upd_valid = 1'b0;
    for (int c = 1; c <= lat; c++) begin
      chk("R1", "busy", 32'(busy), 32'd1);
      chk("R1", "ready", 32'(upd_ready), 32'd0);
      chk("R10", "done", 32'(done), 32'(c == lat));
      chk("R4", "btb_en", 32'(btb_en), 32'(eop[c] != 0));
      if (eop[c] != 0) begin
        chk("R4", "btb_we", 32'(btb_we), 32'(eop[c] == 2));
        chk("R3", "btb_addr", btb_addr, ea[c]);
        if (eop[c] == 2) chk("R9", "btb_wdata", btb_wdata, ed[c]);
      end
      chk("R2", "lru_touch", 32'(lru_touch), 32'(!mis && c == 1));
      if (!mis && c == 1) chk("R2", "lru_addr", lru_addr, bh(pc, ptr));
      if (c == lat) begin
        chk(rq, "res_kind", 32'(res_kind), 32'(kind));
        chk((kind >= 2) ? "R11" : rq, "res_ptr", 32'(res_ptr), 32'(eptr));
        chk(rq, "res_mask", 32'(res_mask), 32'(m));
        chk(rq, "res_train", 32'(res_train), 32'(kind != 0));
      end
      @(negedge clk);
    end
    chk("R1", "idle ready", 32'(upd_ready), 32'd1);
    chk("R1", "idle busy", 32'(busy), 32'd0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] pa, pb, pcc, pd, pe, pf;
    pa = 32'h0004_5670; pb = 32'h0008_9AB0; pcc = 32'h000C_DE00;
    pd = 32'h0010_2200; pe = 32'h0014_3300; pf = 32'h0001_2340;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "reset ready", 32'(upd_ready), 32'd1);
    chk("R1", "reset busy", 32'(busy), 32'd0);
    chk("R10", "reset done", 32'(done), 32'd0);
    chk("R4", "reset btb_en", 32'(btb_en), 32'd0);

    // R2: correct prediction
    run(pf, 32'hAAAA_0001, 4'd5, 1'b0, 1'b1, 16'h0024, 1'b0, "R2");

    // R6: stale pointer, match on third allocated slot
    put(bh(pa, 2), 32'h1000_0002);
    put(bh(pa, 5), 32'h1000_0005);
    put(bh(pa, 9), 32'h1000_0009);
    run(pa, 32'h1000_0009, 4'd2, 1'b1, 1'b1, 16'h0224, 1'b0, "R6");

    // R5: evicted slot cleared, mask written back
    put(bh(pb, 1), 32'h2000_0001);
    put(bh(pb, 5), 32'h2000_0005);
    put(bh(pb, 9), 32'h2000_0009);
    kill(bh(pb, 5));
    run(pb, 32'h2000_0009, 4'd1, 1'b1, 1'b1, 16'h0222, 1'b0, "R5");

    // R7: no match, free slot allocated
    put(bh(pcc, 1), 32'h3000_0001);
    put(bh(pcc, 3), 32'h3000_0003);
    run(pcc, 32'h3000_00FF, 4'd3, 1'b1, 1'b1, 16'h000A, 1'b0, "R7");

    // R8: all slots used, random replacement
    for (int s = 0; s < 16; s++) put(bh(pd, s), 32'h4000_0000 + 32'(s));
    run(pd, 32'h4000_00FF, 4'd7, 1'b1, 1'b1, 16'hFFFF, 1'b0, "R8");

    // R9: missing entry, incoming mask ignored
    run(pe, 32'h5000_0001, 4'd0, 1'b1, 1'b0, 16'hFFFF, 1'b0, "R9");

    // R1: request held through a busy period is taken only after done
    run(pf, 32'hAAAA_0002, 4'd3, 1'b0, 1'b1, 16'h0008, 1'b1, "R1");
    run(pf, 32'hAAAA_0002, 4'd3, 1'b0, 1'b1, 16'h0008, 1'b1, "R1");
    run(pa, 32'h1000_0005, 4'd9, 1'b1, 1'b1, 16'h0224, 1'b0, "R6");

    summary();
    $finish;
  end
endmodule